// File: doc/BRIEF.md
# Run-Time Programmable Multi-Channel CIC Decimator

This block is a cascaded integrator-comb decimator for time-multiplexed sample streams. Signed input samples arrive over a valid/ready stream, one sample per accepted beat. The channel index advances with every beat, from 0 up to `CHANNELS-1`, and then wraps. A group of one beat per channel forms a frame. Each channel has its own set of `STAGES` integrators, which are updated on every accepted beat of that channel. A frame counter selects one frame out of every R. In that frame, each channel's integrator sum passes through `STAGES` comb stages with a differential delay of `DIFF_DLY` (1 or 2) decimated samples. The result is then presented on the output stream together with its channel index.

The internal width is `IN_W + STAGES*ceil(log2(RATE_MAX*DIFF_DLY))` bits, and the integrators wrap in two's complement. The output either carries this full width, or keeps only its top `OUT_W` bits when truncation is selected. The rate R starts at `RATE_INIT`. Software can request a new rate, which is adopted only at the end of a decimation period. The back-pressure rules are as follows. An output beat moves only when `m_tvalid`, `m_tready` and `ce` are all high. While an output beat waits, it is held and `s_tready` is low, so no input is taken. A clock enable freezes every register. Reset is active-low and synchronous, and it is held for at least two cycles.

Top module: `cic_decim`

## Requirements
- R1: After `rst_n` has been low for two or more clock edges, `m_tvalid` is 0, `m_tdata` is 0, `m_tchan` is 0 and `s_tready` is 1 (with `ce` high). The rate is `RATE_INIT`, the channel index is 0, and every integrator and comb delay is zero.
- R2: For each channel, the output sequence equals the sum of the integrator outputs through `STAGES` comb differences. Each comb difference subtracts the value from `DIFF_DLY` decimated samples earlier. The integrators are sampled on the last frame of every R frames, counted from reset.
- R3: Input beats are assigned channels 0,1,…,`CHANNELS-1` in turn. Each output carries the channel of the beat that produced it on `m_tchan`.
- R4: With truncation selected (`FULL_PREC`=0), `m_tdata` is the full-width result arithmetically shifted right by `ACC_W-OUT_W` bits, which keeps its top `OUT_W` bits.
- R5: Each channel produces exactly one output per R frames. While `m_tvalid` is low, `m_tdata` keeps its last value.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` and `m_tdata` hold and `s_tready` is 0.
- R7: A write (`rate_wr`=1 with `ce` high) of a value within [`RATE_MIN`,`RATE_MAX`] is adopted at the end of the current decimation period. The frame counter then restarts from zero.
- R8: A rate write with a value below `RATE_MIN` or above `RATE_MAX` has no effect.
- R9: While `ce` is 0, no register changes: no input is accepted (`s_tready`=0) and the output and all counters hold.
- R10: An output appears right after the clock edge that accepts the last beat of its channel in a selected frame, with a latency of one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, at least two cycles |
| ce | input | 1 | Clock enable; low freezes all state |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Input sample accepted when high together with s_tvalid |
| s_tdata | input | IN_W | Signed input sample |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | OUT_W | Signed decimated output |
| m_tchan | output | CHAN_W | Channel index of the output sample |
| rate_wr | input | 1 | Request a new decimation rate |
| rate_val | input | RATE_W | Requested decimation rate |

## Verification
A beat that completes a selected frame for its channel produces an output that is visible immediately after the accepting edge. The bench therefore checks `m_tvalid` and `m_tchan` one edge after each such beat. It drives inputs at the falling edge and samples two time units later, when both the ready logic and the output register have settled. A reference model in the bench computes the expected output when a beat is accepted and queues it. A monitor compares each handshaked output against that queue, so the order of outputs and any stall cycles do not disturb the comparison. Stall, clock-enable and rate-change phases check holding behaviour at the falling edge following each frozen cycle.

// File: rtl/cic_pkg.sv
package cic_pkg;
  function automatic int acc_width(input int in_w, input int stages,
                                   input int rate_max, input int diff_dly);
    return in_w + stages * $clog2(rate_max * diff_dly);
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
  parameter int CHANNELS  = 2,
  parameter int RATE_MIN  = 4,
  parameter int RATE_MAX  = 64,
  parameter int RATE_INIT = 8,
  parameter int CHAN_W    = 1,
  parameter int RATE_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              beat,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  output logic [CHAN_W-1:0] chan,
  output logic              last_frame
);
  logic [RATE_W-1:0] count;
  logic [RATE_W-1:0] rate;
  logic [RATE_W-1:0] pend_rate;
  logic              pend;
  logic              in_range;
  logic              frame_done;

  assign in_range   = (rate_val >= RATE_W'(RATE_MIN)) && (rate_val <= RATE_W'(RATE_MAX));
  assign last_frame = (count == rate - RATE_W'(1));
  assign frame_done = beat && (chan == CHAN_W'(CHANNELS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan      <= '0;
      count     <= '0;
      rate      <= RATE_W'(RATE_INIT);
      pend_rate <= RATE_W'(RATE_INIT);
      pend      <= 1'b0;
    end else if (ce) begin
      if (beat) begin
        if (frame_done) begin
          chan <= '0;
          if (last_frame) begin
            count <= '0;
            if (pend) begin
              rate <= pend_rate;
              pend <= 1'b0;
            end
          end else begin
            count <= count + RATE_W'(1);
          end
        end else begin
          chan <= chan + CHAN_W'(1);
        end
      end
      if (rate_wr && in_range) begin
        pend      <= 1'b1;
        pend_rate <= rate_val;
      end
    end
  end

  AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate >= RATE_W'(RATE_MIN)) && (rate <= RATE_W'(RATE_MAX))); // R7
  AST_COUNT_BELOW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    count < rate); // R5
  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(count) && $stable(chan) && $stable(rate)); // R9
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int ACC_W    = 33,
  parameter int CHAN_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CHAN_W-1:0] chan,
  input  logic [ACC_W-1:0]  din,
  output logic [ACC_W-1:0]  dout
);
  logic [ACC_W-1:0] sum [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [ACC_W-1:0] acc [CHANNELS];
    logic [ACC_W-1:0] feed;

    if (k == 0) begin : g_first
      assign feed = din;
    end else begin : g_next
      assign feed = sum[k-1];
    end

    assign sum[k] = acc[chan] + feed;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int c = 0; c < CHANNELS; c++) acc[c] <= '0;
      end else if (en) begin
        acc[chan] <= sum[k];
      end
    end
  end

  assign dout = sum[STAGES-1];
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int DIFF_DLY = 2,
  parameter int ACC_W    = 33,
  parameter int CHAN_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CHAN_W-1:0] chan,
  input  logic [ACC_W-1:0]  din,
  output logic [ACC_W-1:0]  dout
);
  logic [ACC_W-1:0] diff [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [ACC_W-1:0] dly [CHANNELS][DIFF_DLY];
    logic [ACC_W-1:0] feed;

    if (k == 0) begin : g_first
      assign feed = din;
    end else begin : g_next
      assign feed = diff[k-1];
    end

    assign diff[k] = feed - dly[chan][DIFF_DLY-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int c = 0; c < CHANNELS; c++)
          for (int j = 0; j < DIFF_DLY; j++) dly[c][j] <= '0;
      end else if (en) begin
        for (int j = DIFF_DLY - 1; j > 0; j--) dly[chan][j] <= dly[chan][j-1];
        dly[chan][0] <= feed;
      end
    end
  end

  assign dout = diff[STAGES-1];
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W      = 12,
  parameter int STAGES    = 3,
  parameter int DIFF_DLY  = 2,
  parameter int CHANNELS  = 2,
  parameter int RATE_MIN  = 4,
  parameter int RATE_MAX  = 64,
  parameter int RATE_INIT = 8,
  parameter bit FULL_PREC = 1'b0,
  parameter int TRUNC_W   = 24,
  localparam int ACC_W    = cic_pkg::acc_width(IN_W, STAGES, RATE_MAX, DIFF_DLY),
  localparam int OUT_W    = FULL_PREC ? ACC_W : TRUNC_W,
  localparam int CHAN_W   = cic_pkg::idx_width(CHANNELS),
  localparam int RATE_W   = $clog2(RATE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [IN_W-1:0]   s_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [OUT_W-1:0]  m_tdata,
  output logic [CHAN_W-1:0] m_tchan,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val
);
  logic              accept;
  logic              dec_beat;
  logic              last_frame;
  logic [CHAN_W-1:0] chan;
  logic [ACC_W-1:0]  din_ext;
  logic [ACC_W-1:0]  integ_out;
  logic [ACC_W-1:0]  comb_out;
  logic [OUT_W-1:0]  out_next;

  assign s_tready = ce && (!m_tvalid || m_tready);
  assign accept   = s_tvalid && s_tready;
  assign dec_beat = accept && last_frame;
  assign din_ext  = {{(ACC_W - IN_W){s_tdata[IN_W-1]}}, s_tdata};

  cic_rate_ctrl #(
    .CHANNELS(CHANNELS), .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX),
    .RATE_INIT(RATE_INIT), .CHAN_W(CHAN_W), .RATE_W(RATE_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .ce(ce), .beat(accept),
    .rate_wr(rate_wr), .rate_val(rate_val),
    .chan(chan), .last_frame(last_frame)
  );

  cic_integ #(
    .STAGES(STAGES), .CHANNELS(CHANNELS), .ACC_W(ACC_W), .CHAN_W(CHAN_W)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .en(accept), .chan(chan),
    .din(din_ext), .dout(integ_out)
  );

  cic_comb #(
    .STAGES(STAGES), .CHANNELS(CHANNELS), .DIFF_DLY(DIFF_DLY),
    .ACC_W(ACC_W), .CHAN_W(CHAN_W)
  ) u_comb (
    .clk(clk), .rst_n(rst_n), .en(dec_beat), .chan(chan),
    .din(integ_out), .dout(comb_out)
  );

  if (FULL_PREC) begin : g_full
    assign out_next = comb_out;
  end else begin : g_trunc
    assign out_next = comb_out[ACC_W-1 -: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tchan  <= '0;
    end else if (ce) begin
      if (dec_beat) begin
        m_tvalid <= 1'b1;
        m_tdata  <= out_next;
        m_tchan  <= chan;
      end else if (m_tready) begin
        m_tvalid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tchan)); // R6
  AST_IDLE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid && $past(!m_tvalid)) |-> $stable(m_tdata)); // R5
  AST_BEAT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> $past(s_tvalid && ce)); // R10
  AST_NO_INPUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(m_tvalid) && $stable(m_tdata)); // R9
endmodule

// File: tb/test_cic_decim.sv
module test_cic_decim;
  localparam int IN_W = 12, N = 3, M = 2, CH = 2;
  localparam int RMIN = 4, RMAX = 64, RINIT = 8;
  localparam int ACC_W = IN_W + N * $clog2(RMAX * M);
  localparam int OUT_W = 24;
  localparam int SH = ACC_W - OUT_W;
  localparam int CW = 1, RW = $clog2(RMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [IN_W-1:0] s_tdata = '0;
  logic m_tvalid;
  logic m_tready = 1'b1;
  logic [OUT_W-1:0] m_tdata;
  logic [CW-1:0] m_tchan;
  logic rate_wr = 1'b0;
  logic [RW-1:0] rate_val = '0;

  always #2.5 clk = ~clk;

  cic_decim #(
    .IN_W(IN_W), .STAGES(N), .DIFF_DLY(M), .CHANNELS(CH), .RATE_MIN(RMIN),
    .RATE_MAX(RMAX), .RATE_INIT(RINIT), .FULL_PREC(1'b0), .TRUNC_W(OUT_W)
  ) i_cic_decim (
    .clk(clk), .rst_n(rst_n), .ce(ce), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tdata(s_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tchan(m_tchan), .rate_wr(rate_wr), .rate_val(rate_val)
  );

  int n_chk = 0, n_bad = 0;
  string phase = "R2";
  int rdy_mode = 0;
  int cyc = 0;

  longint exp_q[$];
  int     chn_q[$];
  longint mi[CH][N];
  longint md[CH][N][M];
  int mch, mcnt, mrate, mpend, mpv;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < CH; c++)
      for (int k = 0; k < N; k++) begin
        mi[c][k] = 0;
        for (int j = 0; j < M; j++) md[c][k][j] = 0;
      end
    mch = 0; mcnt = 0; mrate = RINIT; mpend = 0; mpv = RINIT;
    exp_q.delete();
    chn_q.delete();
  endtask

  // Reference model of one accepted beat; returns whether it produced an output.
  task automatic model_beat(input longint d, output bit produced, output int pc);
    longint s, v, t;
    s = d;
    for (int k = 0; k < N; k++) begin
      mi[mch][k] += s;
      s = mi[mch][k];
    end
    produced = (mcnt == mrate - 1);
    pc = mch;
    if (produced) begin
      v = s;
      for (int k = 0; k < N; k++) begin
        t = v - md[mch][k][M-1];
        for (int j = M - 1; j > 0; j--) md[mch][k][j] = md[mch][k][j-1];
        md[mch][k][0] = v;
        v = t;
      end
      exp_q.push_back(v >>> SH);  // R4: top OUT_W bits
      chn_q.push_back(mch);
    end
    if (mch == CH - 1) begin
      mch = 0;
      if (mcnt == mrate - 1) begin
        mcnt = 0;
        if (mpend != 0) begin mrate = mpv; mpend = 0; end
      end else mcnt++;
    end else mch++;
  endtask

  task automatic send(input int d);
    bit prod;
    int pc;
    @(negedge clk);
    s_tvalid = 1'b1;
    s_tdata = IN_W'(d);
    #2;
    while (!s_tready) begin
      @(negedge clk);
      #2;
    end
    model_beat(longint'(d), prod, pc);
    @(posedge clk);
    #1;
    s_tvalid = 1'b0;
    if (prod) begin
      check(m_tvalid == 1'b1, "R10", longint'(m_tvalid), 1);
      check(int'(m_tchan) == pc, "R3", longint'(m_tchan), longint'(pc));
    end
  endtask

  task automatic load_rate(input int v);
    @(negedge clk);
    rate_wr = 1'b1;
    rate_val = RW'(v);
    #2;
    if (ce && v >= RMIN && v <= RMAX) begin mpend = 1; mpv = v; end
    @(posedge clk);
    #1;
    rate_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_tvalid = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  function automatic int pattern(input int i);
    return ((i * 37 + 101) % 4096) - 2048;
  endfunction

  // Monitor / scoreboard
  logic [OUT_W-1:0] prev_data;
  logic prev_valid = 1'b0, prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      m_tready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      #2;
      if (rst_n) begin
        if (prev_stall)
          check(m_tvalid && m_tdata == prev_data, "R6", longint'(m_tdata), longint'(prev_data));
        if (!m_tvalid && !prev_valid)
          check(m_tdata == prev_data, "R5", longint'(m_tdata), longint'(prev_data));
        if (m_tvalid && !m_tready)
          check(s_tready == 1'b0, "R6", longint'(s_tready), 0);
        if (m_tvalid && m_tready && ce) begin
          if (exp_q.size() == 0) begin
            check(1'b0, {phase, " unexpected output"}, longint'($signed(m_tdata)), 0);
          end else begin
            longint e;
            int ec;
            e = exp_q.pop_front();
            ec = chn_q.pop_front();
            check(longint'($signed(m_tdata)) == e, phase, longint'($signed(m_tdata)), e);
            check(int'(m_tchan) == ec, "R3", longint'(m_tchan), longint'(ec));
          end
        end
        prev_stall = m_tvalid && !m_tready && ce;
      end else begin
        prev_stall = 1'b0;
      end
      prev_valid = m_tvalid || !rst_n;
      prev_data = m_tdata;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
    finish_run();
  end

  initial begin
    logic [OUT_W-1:0] hd;
    logic hv;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check(m_tvalid == 1'b0, "R1", longint'(m_tvalid), 0);
    check(m_tdata == '0, "R1", longint'(m_tdata), 0);
    check(m_tchan == '0, "R1", longint'(m_tchan), 0);
    check(s_tready == 1'b1, "R1", longint'(s_tready), 1);

    // R2/R3/R10: ramp-like pattern, full ready
    phase = "R2";
    for (int i = 0; i < CH * RINIT * 6; i++) send(pattern(i));

    // R6: back-pressure
    phase = "R6";
    rdy_mode = 1;
    for (int i = 0; i < CH * RINIT * 5; i++) send(pattern(i + 500));
    rdy_mode = 0;

    // R9: clock enable low freezes everything
    phase = "R9";
    for (int i = 0; i < CH * RINIT * 2 - 1; i++) send(pattern(i + 900));
    @(negedge clk);
    ce = 1'b0;
    s_tvalid = 1'b1;
    s_tdata = IN_W'(77);
    #2;
    hd = m_tdata;
    hv = m_tvalid;
    for (int i = 0; i < 4; i++) begin
      check(s_tready == 1'b0, "R9", longint'(s_tready), 0);
      @(negedge clk);
      #2;
      check(m_tvalid == hv && m_tdata == hd, "R9", longint'(m_tdata), longint'(hd));
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    ce = 1'b1;
    for (int i = 0; i < CH * RINIT * 3; i++) send(pattern(i + 1300));

    // R7: in-range rate change mid-period
    phase = "R7";
    for (int i = 0; i < CH * 3; i++) send(pattern(i + 1700));
    load_rate(5);
    for (int i = 0; i < CH * 5 * 8; i++) send(pattern(i + 1800));
    load_rate(RMIN);
    for (int i = 0; i < CH * RMIN * 8; i++) send(pattern(i + 2100));

    // R8: out-of-range writes ignored
    phase = "R8";
    load_rate(RMIN - 1);
    for (int i = 0; i < CH * RMIN * 4; i++) send(pattern(i + 2400));
    load_rate(RMAX + 1);
    for (int i = 0; i < CH * RMIN * 4; i++) send(pattern(i + 2600));

    // R4: large constant input exercises the top bits of the full result
    phase = "R4";
    load_rate(RMAX);
    for (int i = 0; i < CH * RMIN; i++) send(-2048);
    for (int i = 0; i < CH * RMAX * 3; i++) send((i % CH == 0) ? -2048 : 2047);

    // R1: mid-run reset clears integrators and combs
    phase = "R1";
    do_reset();
    #2;
    check(m_tvalid == 1'b0, "R1", longint'(m_tvalid), 0);
    check(m_tdata == '0, "R1", longint'(m_tdata), 0);
    for (int i = 0; i < CH * RINIT * 4; i++) send(pattern(i + 3000));

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R5", longint'(exp_q.size()), 0);
    finish_run();
  end
endmodule